// File: doc/BRIEF.md
# Endpoint Control and Status Register Bank

This block keeps the per-endpoint control words of a full-speed USB device controller: one 16-bit word for each of eight endpoints. Each word carries the endpoint address, its transfer type, a kind bit, the receive and transmit handshake status, the receive and transmit data toggles, the receive and transmit transfer-complete flags, and a flag for a finished SETUP stage. Software writes a whole word through a write port and reads any word back through a read port. The fields in one word obey different write rules. The handshake-status and data-toggle bits invert where a 1 is written. The transfer-complete flags clear where a 0 is written and ignore a 1. Address, type and kind take the written value.

The transaction engine reports each finished transaction on a separate event port. It names the endpoint, the direction and whether the transaction was a SETUP. The bank then raises the matching transfer-complete flag and inverts the matching data toggle. All ports are plain control and status pins: a write or an event takes one cycle, and no port applies back-pressure. Type encoding: 00 bulk, 01 control, 10 isochronous, 11 interrupt. The kind bit selects double buffering for a bulk endpoint and status-out handling for a control endpoint. Status encoding, for both directions: 00 disabled, 01 stall, 10 NAK, 11 valid.

Top module: `ep_ctrl_bank`

## Requirements
- R1: After reset every endpoint word reads 0x0000, so every endpoint starts disabled.
- R2: A write stores wr_data[3:0] as the address, wr_data[10:9] as the type and wr_data[8] as the kind bit.
- R3: Receive status at bits 13:12 inverts each bit written as 1 and keeps each bit written as 0.
- R4: Transmit status at bits 5:4 inverts each bit written as 1 and keeps each bit written as 0.
- R5: The data toggles at bit 14 (receive) and bit 6 (transmit) invert on a written 1 and hold on a written 0.
- R6: The transfer-complete flags at bit 15 (receive) and bit 7 (transmit) clear on a written 0 and hold on a written 1.
- R7: Bit 11 (SETUP done) ignores written data. A receive event with evt_setup=1 sets it. A write that clears bit 15 clears it.
- R8: A receive event (evt_tx=0) sets bit 15 and inverts bit 14 of the named endpoint. A transmit event (evt_tx=1) sets bit 7 and inverts bit 6. No other bit of that word changes.
- R9: When an event and a write that clears the same transfer-complete flag land in one cycle, the flag ends set. Each data-toggle inversion applies, so a written 1 and an event cancel out.
- R10: A write or an event changes only the endpoint that wr_idx or evt_idx names.
- R11: rd_data shows the word selected by rd_idx combinationally. A write or event shows on rd_data in the cycle after the clock edge that accepted it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_idx | input | 3 | Endpoint written |
| wr_data | input | 16 | Written word |
| rd_idx | input | 3 | Endpoint read |
| rd_data | output | 16 | Word of endpoint rd_idx |
| evt_en | input | 1 | Transaction-complete event strobe |
| evt_idx | input | 3 | Endpoint of the event |
| evt_tx | input | 1 | 1: transmit (IN) transaction, 0: receive (OUT/SETUP) |
| evt_setup | input | 1 | Receive event was a SETUP |

## Verification
Every write and event is captured at the rising edge where its strobe is high, and it is visible on rd_data from that edge on, because the read path adds no register. The bench drives all inputs at falling edges and holds each for one cycle. A read is issued at a falling edge with both strobes low, and the scoreboard samples it at the next rising edge, so each read sees the effect of every earlier write and event. The same-cycle cases are driven in one cycle and read back in a later one.

// File: rtl/ep_bank_pkg.sv
package ep_bank_pkg;
  typedef struct packed {
    logic       rx_ctr;
    logic       rx_dtog;
    logic [1:0] rx_stat;
    logic       setup;
    logic [1:0] ep_type;
    logic       kind;
    logic       tx_ctr;
    logic       tx_dtog;
    logic [1:0] tx_stat;
    logic [3:0] addr;
  } ep_word_t;

  localparam int unsigned EP_WORD_W = $bits(ep_word_t);
endpackage

// File: rtl/ep_slot.sv
module ep_slot
  import ep_bank_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_hit,
  input  ep_word_t wr_word,
  input  logic     ev_hit,
  input  logic     ev_tx,
  input  logic     ev_setup,
  output ep_word_t q
);
  ep_word_t nx;

  always_comb begin
    nx = q;
    if (wr_hit) begin
      nx.addr    = wr_word.addr;
      nx.ep_type = wr_word.ep_type;
      nx.kind    = wr_word.kind;
      nx.rx_stat = q.rx_stat ^ wr_word.rx_stat;
      nx.tx_stat = q.tx_stat ^ wr_word.tx_stat;
      nx.rx_dtog = q.rx_dtog ^ wr_word.rx_dtog;
      nx.tx_dtog = q.tx_dtog ^ wr_word.tx_dtog;
      nx.rx_ctr  = q.rx_ctr & wr_word.rx_ctr;
      nx.tx_ctr  = q.tx_ctr & wr_word.tx_ctr;
      if (!wr_word.rx_ctr) nx.setup = 1'b0;
    end
    if (ev_hit) begin
      if (ev_tx) begin
        nx.tx_ctr  = 1'b1;
        nx.tx_dtog = ~nx.tx_dtog;
      end else begin
        nx.rx_ctr  = 1'b1;
        nx.rx_dtog = ~nx.rx_dtog;
        if (ev_setup) nx.setup = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nx;
  end

  assert_plain_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (q.addr == $past(wr_word.addr)) && (q.ep_type == $past(wr_word.ep_type))
               && (q.kind == $past(wr_word.kind)));

  assert_stat_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(q.rx_stat) && $stable(q.tx_stat));

  assert_rx_tog_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit && !ev_tx && !wr_hit) |=> (q.rx_dtog != $past(q.rx_dtog)));

  assert_rx_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit && !ev_tx) |=> q.rx_ctr);

  assert_tx_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_hit && ev_tx) |=> q.tx_ctr);

  assert_setup_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q.setup) |-> $past(ev_hit && !ev_tx && ev_setup));
endmodule

// File: rtl/ep_read_mux.sv
module ep_read_mux
  import ep_bank_pkg::*;
#(
  parameter int unsigned N_EP  = 8,
  parameter int unsigned IDX_W = 3
) (
  input  ep_word_t             words [N_EP],
  input  logic     [IDX_W-1:0] sel,
  output ep_word_t             word
);
  always_comb begin
    word = '0;
    for (int unsigned k = 0; k < N_EP; k++)
      if (sel == IDX_W'(k)) word = words[k];
  end
endmodule

// File: rtl/ep_ctrl_bank.sv
module ep_ctrl_bank
  import ep_bank_pkg::*;
#(
  parameter int unsigned N_EP = 8,
  localparam int unsigned IDX_W = (N_EP > 1) ? $clog2(N_EP) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [EP_WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [EP_WORD_W-1:0] rd_data,
  input  logic                 evt_en,
  input  logic [IDX_W-1:0]     evt_idx,
  input  logic                 evt_tx,
  input  logic                 evt_setup
);
  ep_word_t words [N_EP];
  ep_word_t rd_word;

  for (genvar g = 0; g < N_EP; g++) begin : g_slot
    ep_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (wr_en && (wr_idx == IDX_W'(g))),
      .wr_word  (ep_word_t'(wr_data)),
      .ev_hit   (evt_en && (evt_idx == IDX_W'(g))),
      .ev_tx    (evt_tx),
      .ev_setup (evt_setup),
      .q        (words[g])
    );
  end

  ep_read_mux #(.N_EP(N_EP), .IDX_W(IDX_W)) u_rd (
    .words (words),
    .sel   (rd_idx),
    .word  (rd_word)
  );

  assign rd_data = rd_word;

  assert_untouched_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !evt_en) |=> $stable(rd_data) || !$stable(rd_idx));
endmodule

// File: tb/ep_ctrl_bank_tb_top.sv
`timescale 1ns/1ps
module ep_ctrl_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_idx = '0;
  logic [15:0] rd_data;
  logic        evt_en = 1'b0;
  logic [2:0]  evt_idx = '0;
  logic        evt_tx = 1'b0;
  logic        evt_setup = 1'b0;

  int total = 0;
  int bad = 0;
  logic [15:0] model [8];
  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic        rd_chk = 1'b0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  ep_ctrl_bank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .evt_en(evt_en), .evt_idx(evt_idx),
    .evt_tx(evt_tx), .evt_setup(evt_setup)
  );

  function automatic logic [15:0] m_write(logic [15:0] m, logic [15:0] d);
    logic [15:0] r;
    r = m;
    r[3:0]   = d[3:0];
    r[10:8]  = d[10:8];
    r[13:12] = m[13:12] ^ d[13:12];
    r[5:4]   = m[5:4] ^ d[5:4];
    r[14]    = m[14] ^ d[14];
    r[6]     = m[6] ^ d[6];
    r[15]    = m[15] & d[15];
    r[7]     = m[7] & d[7];
    if (!d[15]) r[11] = 1'b0;
    return r;
  endfunction

  function automatic logic [15:0] m_event(logic [15:0] m, logic tx, logic su);
    logic [15:0] r;
    r = m;
    if (tx) begin r[7] = 1'b1; r[6] = ~m[6]; end
    else begin r[15] = 1'b1; r[14] = ~m[14]; if (su) r[11] = 1'b1; end
    return r;
  endfunction

  task automatic do_step(input logic we, input logic [2:0] wi, input logic [15:0] wd,
                         input logic ee, input logic [2:0] ei, input logic et, input logic es);
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_data = wd;
    evt_en = ee; evt_idx = ei; evt_tx = et; evt_setup = es;
    if (we) model[wi] = m_write(model[wi], wd);
    if (ee) model[ei] = m_event(model[ei], et, es);
    @(negedge clk);
    wr_en = 1'b0; evt_en = 1'b0;
  endtask

  task automatic do_write(input logic [2:0] i, input logic [15:0] d);
    do_step(1'b1, i, d, 1'b0, 3'd0, 1'b0, 1'b0);
  endtask

  task automatic do_event(input logic [2:0] i, input logic tx, input logic su);
    do_step(1'b0, 3'd0, 16'h0, 1'b1, i, tx, su);
  endtask

  task automatic do_read(input logic [2:0] i, input string tag);
    @(negedge clk);
    wr_en = 1'b0; evt_en = 1'b0;
    rd_idx = i; rd_chk = 1'b1;
    exp_q.push_back(model[i]);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_chk = 1'b0;
  endtask

  always @(posedge clk) begin
    if (rd_chk && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (rd_data !== e) begin
        bad++;
        $display("FAIL %s ep=%0d actual=%04h expected=%04h", t, rd_idx, rd_data, e);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) model[k] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) do_read(k[2:0], "R1 reset");
    // R2 R3 R4: addr 5, control type, kind set, rx stat -> valid, tx stat -> NAK
    do_write(3'd2, 16'h8080 | 16'h3000 | 16'h0200 | 16'h0100 | 16'h0020 | 16'h0005);
    do_read(3'd2, "R2 R3 R4 first write");
    // R3: write 01 to rx status -> 11 becomes 10; R4: write 11 to tx -> 10 becomes 01
    do_write(3'd2, 16'h8080 | 16'h1000 | 16'h0030 | 16'h0205);
    do_read(3'd2, "R3 R4 toggle");
    do_read(3'd1, "R10 neighbour");
    // R8 R7: setup receive event
    do_event(3'd2, 1'b0, 1'b1);
    do_read(3'd2, "R8 R7 rx setup event");
    // R7 R6: writing 1 to bit15 and 0 to bit11 keeps both
    do_write(3'd2, 16'h8080 | 16'h0205);
    do_read(3'd2, "R7 R6 hold");
    // R6 R7: writing 0 to bit15 clears flag and setup
    do_write(3'd2, 16'h0080 | 16'h0205);
    do_read(3'd2, "R6 R7 clear");
    // R8 transmit event
    do_event(3'd3, 1'b1, 1'b0);
    do_read(3'd3, "R8 tx event");
    do_read(3'd2, "R10 other ep");
    // R9: clear tx flag and event in same cycle; dtog: written 1 plus event
    do_step(1'b1, 3'd3, 16'h8040, 1'b1, 3'd3, 1'b1, 1'b0);
    do_read(3'd3, "R9 set wins");
    // R9 receive side, setup in same cycle as a clear
    do_event(3'd4, 1'b0, 1'b0);
    do_step(1'b1, 3'd4, 16'h0080, 1'b1, 3'd4, 1'b0, 1'b1);
    do_read(3'd4, "R9 rx set wins");
    // R5: data toggles via writes
    do_write(3'd5, 16'h40C0);
    do_read(3'd5, "R5 toggle once");
    do_write(3'd5, 16'h4040 | 16'h0080 | 16'h0600 | 16'h000F);
    do_read(3'd5, "R5 toggle twice R2");
    do_write(3'd5, 16'h0080 | 16'h0600 | 16'h000F);
    do_read(3'd5, "R5 hold on zero");
    // R11: immediate read of last write endpoint
    do_write(3'd7, 16'h8080 | 16'h2000 | 16'h0010 | 16'h0409);
    do_read(3'd7, "R11 next cycle");
    for (int k = 0; k < 8; k++) do_read(k[2:0], "R10 final sweep");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule